// File: doc/BRIEF.md
# Selective Extended-Period Self-Refresh Scheduler

This block decides which DRAM row gets refreshed on each internal tick while the device sits in self-refresh. The refresh period is stretched to several times the normal one. Each long period is divided into `PERIOD_TICKS` ticks. In the opening `ROWS` ticks every row is refreshed once, in ascending order. In the remaining ticks the row counter keeps sweeping and wrapping, but a refresh is only issued for rows whose group is marked in a weak-retention map. A marked row therefore gets one extra refresh for every later pass. An unmarked row gets only the single refresh of the opening sweep.

The weak map is a static bit vector supplied by fuses. Each bit covers `GROUP_ROWS` consecutive rows. The block emits a one-cycle strobe and the row address for each refresh. The strobe is a pulse with no back-pressure: the array must accept it, so the interface has no ready signal. The tick source, the array and the redundancy that replaces very weak bits all sit outside this block.

Top module: `srf_sched`

## Requirements
- R1: During and directly after reset, `rfsh_stb` is 0 and `rfsh_row` is 0.
- R2: While `sr_en` is 0, a `tick` produces no strobe, and the tick and row counters are held at zero.
- R3: The first tick after `sr_en` rises starts a new period and refreshes row 0. This holds after any earlier exit, whatever the position reached before the exit.
- R4: For the first `ROWS` ticks of a period, every tick produces a strobe. The rows come out as 0, 1, … `ROWS-1` in order.
- R5: For ticks `ROWS` to `PERIOD_TICKS-1` of a period, the row counter still advances by one per tick and wraps from `ROWS-1` to 0. A strobe is issued only when the map bit of the current row is 1.
- R6: Map bit g is selected by the row address with its low log2(`GROUP_ROWS`) bits dropped. It covers rows g·`GROUP_ROWS` to g·`GROUP_ROWS`+`GROUP_ROWS`-1. Bit 0 is the LSB of `weak_map`.
- R7: Over one full period, a row in a marked group receives `PERIOD_TICKS/ROWS` strobes. Every other row receives exactly one.
- R8: After `PERIOD_TICKS` ticks, the next tick begins a new sweep at row 0.
- R9: A strobe is high for exactly one clock: the cycle after the clock edge that sampled `tick`. `rfsh_row` is valid with it and holds its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_en | input | 1 | Self-refresh mode active |
| tick | input | 1 | One-cycle pulse from the refresh timebase |
| weak_map | input | ROWS/GROUP_ROWS | Weak-retention group flags, one bit per group |
| rfsh_stb | output | 1 | One-cycle refresh strobe |
| rfsh_row | output | log2(ROWS) | Row to refresh, valid with the strobe |

## Verification
The bench builds the block with `ROWS`=32, `GROUP_ROWS`=4 and `PERIOD_TICKS`=128. This gives eight groups and a full period of 128 ticks. At that size the bench can cover whole periods many times over and count the strobes for every row against the map, including the row-counter wraps inside the selective passes and the wrap at the period boundary. Random maps and random gaps between ticks are mixed with all-clear, all-set and single-group maps, and with exit and re-entry at arbitrary points in a period.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic {
    PH_SWEEP  = 1'b0,
    PH_SELECT = 1'b1
  } srf_phase_e;
endpackage

// File: rtl/srf_tick_ctr.sv
module srf_tick_ctr
  import srf_pkg::*;
#(
  parameter int ROWS         = 8192,
  parameter int PERIOD_TICKS = 32768
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      tick,
  output logic [$clog2(ROWS)-1:0]   row,
  output srf_phase_e                phase
);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int TICK_W = $clog2(PERIOD_TICKS);

  logic [TICK_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      tick_cnt <= '0;
      row      <= '0;
    end else if (tick) begin
      tick_cnt <= (tick_cnt == TICK_W'(PERIOD_TICKS - 1)) ? '0 : tick_cnt + 1'b1;
      row      <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
    end
  end

  always_comb begin
    phase = ({1'b0, tick_cnt} < (TICK_W + 1)'(ROWS)) ? PH_SWEEP : PH_SELECT;
  end

  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (row == '0 && tick_cnt == '0));

  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && row != ROW_W'(ROWS - 1)) |=> row == $past(row) + 1'b1);

  // R8
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && tick_cnt == TICK_W'(PERIOD_TICKS - 1)) |=> (tick_cnt == '0 && row == '0));
endmodule

// File: rtl/srf_weak_lookup.sv
module srf_weak_lookup #(
  parameter int ROWS       = 8192,
  parameter int GROUP_ROWS = 4
) (
  input  logic [$clog2(ROWS)-1:0]    row,
  input  logic [ROWS/GROUP_ROWS-1:0] weak_map,
  output logic                       hit
);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int GRP_SH = $clog2(GROUP_ROWS);
  localparam int GRP_W  = ROW_W - GRP_SH;

  logic [GRP_W-1:0] grp_idx;

  generate
    if (GRP_SH == 0) begin : g_flat
      assign grp_idx = row;
    end else begin : g_coarse
      assign grp_idx = row[ROW_W-1:GRP_SH];
    end
  endgenerate

  assign hit = weak_map[grp_idx];
endmodule

// File: rtl/srf_strobe_gen.sv
module srf_strobe_gen
  import srf_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  srf_phase_e       phase,
  input  logic             hit,
  input  logic [ROW_W-1:0] row,
  output logic             stb,
  output logic [ROW_W-1:0] row_o
);
  logic fire;

  always_comb begin
    fire = en && tick && (phase == PH_SWEEP || hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb   <= 1'b0;
      row_o <= '0;
    end else begin
      stb <= fire;
      if (fire) row_o <= row;
    end
  end

  // R9
  stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> $past(en && tick));

  // R4
  sweep_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && phase == PH_SWEEP) |=> (stb && row_o == $past(row)));

  // R9
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |-> $stable(row_o));
endmodule

// File: rtl/srf_sched.sv
module srf_sched
  import srf_pkg::*;
#(
  parameter int ROWS         = 8192,
  parameter int GROUP_ROWS   = 4,
  parameter int PERIOD_TICKS = 32768
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sr_en,
  input  logic                       tick,
  input  logic [ROWS/GROUP_ROWS-1:0] weak_map,
  output logic                       rfsh_stb,
  output logic [$clog2(ROWS)-1:0]    rfsh_row
);
  localparam int ROW_W = $clog2(ROWS);

  logic [ROW_W-1:0] cur_row;
  srf_phase_e       phase;
  logic             weak_hit;

  srf_tick_ctr #(
    .ROWS(ROWS),
    .PERIOD_TICKS(PERIOD_TICKS)
  ) u_ctr (
    .clk(clk),
    .rst_n(rst_n),
    .en(sr_en),
    .tick(tick),
    .row(cur_row),
    .phase(phase)
  );

  srf_weak_lookup #(
    .ROWS(ROWS),
    .GROUP_ROWS(GROUP_ROWS)
  ) u_lookup (
    .row(cur_row),
    .weak_map(weak_map),
    .hit(weak_hit)
  );

  srf_strobe_gen #(
    .ROW_W(ROW_W)
  ) u_stb (
    .clk(clk),
    .rst_n(rst_n),
    .en(sr_en),
    .tick(tick),
    .phase(phase),
    .hit(weak_hit),
    .row(cur_row),
    .stb(rfsh_stb),
    .row_o(rfsh_row)
  );

  // R2
  idle_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_en |=> !rfsh_stb);

  // R3
  entry_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!sr_en) && sr_en && tick) |=> (rfsh_stb && rfsh_row == '0));
endmodule

// File: tb/srf_sched_tb_top.sv
module srf_sched_tb_top;
  localparam int ROWS = 32;
  localparam int GRP  = 4;
  localparam int PER  = 128;
  localparam int NG   = ROWS / GRP;
  localparam int RW   = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_en = 1'b0;
  logic tick = 1'b0;
  logic [NG-1:0] weak_map = '0;
  logic rfsh_stb;
  logic [RW-1:0] rfsh_row;

  int tests = 0;
  int fails = 0;
  int mt = 0;
  int mr = 0;
  int last_row = 0;
  int cnt [ROWS];
  bit done = 0;

  always #10 clk = ~clk;

  srf_sched #(.ROWS(ROWS), .GROUP_ROWS(GRP), .PERIOD_TICKS(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .sr_en(sr_en), .tick(tick),
    .weak_map(weak_map), .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_fire(input bit en, input int t, input int r,
                                  input logic [NG-1:0] m);
    return en && (t < ROWS || m[r / GRP]);
  endfunction

  function automatic int exp_count(input int r, input logic [NG-1:0] m);
    return m[r / GRP] ? PER / ROWS : 1;
  endfunction

  task automatic set_en(input bit en);
    @(negedge clk);
    sr_en = en;
    if (!en) begin mt = 0; mr = 0; end
  endtask

  task automatic do_tick(input bit en, input string tag);
    bit f;
    int er;
    @(negedge clk);
    f = exp_fire(en, mt, mr, weak_map);
    er = f ? mr : last_row;
    sr_en = en;
    tick = 1'b1;
    if (en) begin
      mt = (mt + 1) % PER;
      mr = (mr + 1) % ROWS;
    end else begin
      mt = 0; mr = 0;
    end
    @(negedge clk);
    tick = 1'b0;
    chk(rfsh_stb == f, tag, "strobe", int'(rfsh_stb), int'(f));
    chk(int'(rfsh_row) == er, tag, "row", int'(rfsh_row), er);
    if (rfsh_stb) cnt[rfsh_row]++;
    last_row = er;
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(rfsh_stb == 1'b0, "R9", "strobe in gap", int'(rfsh_stb), 0);
    end
  endtask

  task automatic run_period(input string ctag);
    foreach (cnt[i]) cnt[i] = 0;
    for (int k = 0; k < PER; k++) begin
      if (k == 0 && ctag == "R8") do_tick(1'b1, "R8");
      else do_tick(1'b1, (mt < ROWS) ? "R4" : "R5");
    end
    for (int r = 0; r < ROWS; r++)
      chk(cnt[r] == exp_count(r, weak_map), ctag, "per-row count", cnt[r],
          exp_count(r, weak_map));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1
    chk(rfsh_stb == 1'b0, "R1", "strobe in reset", int'(rfsh_stb), 0);
    chk(rfsh_row == '0, "R1", "row in reset", int'(rfsh_row), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rfsh_stb == 1'b0, "R1", "strobe after reset", int'(rfsh_stb), 0);
    chk(rfsh_row == '0, "R1", "row after reset", int'(rfsh_row), 0);

    // R2: ticks while idle
    for (int i = 0; i < 10; i++) do_tick(1'b0, "R2");

    // R3 + R7 with random map
    weak_map = NG'($urandom);
    set_en(1'b1);
    do_tick(1'b1, "R3");
    mt = 0; mr = 0;
    set_en(1'b0);
    set_en(1'b1);
    run_period("R7");
    run_period("R8");

    // R6: single group marked
    weak_map = '0;
    weak_map[3] = 1'b1;
    set_en(1'b0);
    set_en(1'b1);
    run_period("R6");

    // R5: all clear, then all set
    weak_map = '0;
    run_period("R5");
    weak_map = '1;
    run_period("R5");

    // R3: exit mid-period, idle ticks, re-enter
    for (int n = 0; n < 6; n++) begin
      weak_map = NG'($urandom);
      for (int k = 0; k < int'($urandom_range(1, PER + 40)); k++)
        do_tick(1'b1, (mt < ROWS) ? "R4" : "R5");
      do_tick(1'b0, "R2");
      set_en(1'b0);
      set_en(1'b1);
      do_tick(1'b1, "R3");
      set_en(1'b0);
      set_en(1'b1);
      run_period("R7");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule